// File: doc/BRIEF.md
# External Line Interrupt and Event Controller

This block watches sixteen external lines and turns their edges into interrupt requests and event pulses. Each line n can be fed from pin n of any of several input ports; a 4-bit source index per line picks the port. The chosen pin is brought into the clock domain by a two-flop synchroniser. Its edges are then found by comparing the current synchronised value with the value of the cycle before.

Per line, software enables triggering on rising edges, on falling edges, or on both. Two independent masks then route a triggered edge. The interrupt mask latches the edge into a pending bit, which drives the interrupt request for that line until software clears it by writing 1. The event mask forwards the edge as a one-cycle pulse that never touches the pending state. Configuration goes through a simple synchronous register bus with a combinational read path. The bus has no flow control: a write takes effect on the clock edge where select and write are both high, and nothing in the block carries a data stream that would need back-pressure.

Top module: `xline_irq_ctrl`

## Requirements
- R1: After reset all source selects, trigger enables, both masks and the pending bits are zero; every register reads 0 and irq_out and evt_out are 0.
- R2: Register address a (0..3) holds the source index of lines 4a..4a+3, line n in bits [4(n mod 4)+3 : 4(n mod 4)], readable as written; line n then follows port_pins[p*16+n] for index p, and an index of 4 or more gives a constant 0 source.
- R3: With the rising enable (address 4, bit n) set, a 0-to-1 change of the selected pin triggers line n, and a 1-to-0 change does not.
- R4: With the falling enable (address 5, bit n) set, a 1-to-0 change triggers line n, and a 0-to-1 change does not.
- R5: With both enables set, either change triggers line n.
- R6: A trigger sets pending bit n only when the interrupt mask (address 6, bit n) is 1; irq_out[n] equals pending bit n and rises three clock edges after the edge that first samples the new pin level.
- R7: Writing the pending register (address 8) clears each bit written as 1 and leaves bits written as 0; the pending register reads back its current state.
- R8: When a trigger with interrupt mask set and a clear of the same bit fall on the same clock edge, the bit stays set.
- R9: With the event mask (address 7, bit n) set, a trigger gives evt_out[n] high for exactly one cycle, two edges after the edge that first samples the pin; the event path does not depend on the interrupt mask and the interrupt path does not depend on the event mask.
- R10: A pin change on a line with neither trigger enabled produces neither an event pulse nor a pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_pins | input | 64 | Pin levels of all ports; pin n of port p at bit p*16+n |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_out | output | 16 | Interrupt request per line (pending state) |
| evt_out | output | 16 | One-cycle event pulse per line |

## Verification
The two functions that can meet on one clock edge are a pending bit being set by a fresh trigger and the same bit being cleared by a write of 1 to the pending register. The bench provokes this by changing a pin with both edges enabled and timing a clear write so that it lands on the third edge after the pin is sampled, the edge on which the set arrives. It judges the case at the output: irq_out for that line must still be high afterwards. A plain clear on a later edge must then bring it low.

// File: rtl/xl_pkg.sv
package xl_pkg;
  // Select fields packed per select register
  localparam int LINES_PER_SEL = 4;

  // Registers that follow the select registers, as offsets from the
  // first address after them
  typedef enum logic [2:0] {
    CF_RISE = 3'd0,
    CF_FALL = 3'd1,
    CF_IMSK = 3'd2,
    CF_EMSK = 3'd3,
    CF_PEND = 3'd4
  } cfg_idx_e;
endpackage

// File: rtl/xl_regs.sv
module xl_regs
  import xl_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int SEL_W  = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic [NLINES-1:0]       pend,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic [NLINES*SEL_W-1:0] sel_flat,
  output logic [NLINES-1:0]       rise_en,
  output logic [NLINES-1:0]       fall_en,
  output logic [NLINES-1:0]       imask,
  output logic [NLINES-1:0]       emask,
  output logic [NLINES-1:0]       clr_vec
);
  localparam int NSEL   = NLINES / LINES_PER_SEL;
  localparam int SELR_W = LINES_PER_SEL * SEL_W;
  localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(NSEL + int'(CF_RISE));
  localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(NSEL + int'(CF_FALL));
  localparam logic [ADDR_W-1:0] A_IMSK = ADDR_W'(NSEL + int'(CF_IMSK));
  localparam logic [ADDR_W-1:0] A_EMSK = ADDR_W'(NSEL + int'(CF_EMSK));
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(NSEL + int'(CF_PEND));

  logic             wr_en;
  logic [SELR_W-1:0] sel_q [NSEL];

  assign wr_en = bus_sel & bus_wr;

  for (genvar r = 0; r < NSEL; r++) begin : g_selreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sel_q[r] <= '0;
      else if (wr_en && bus_addr == ADDR_W'(r))
        sel_q[r] <= bus_wdata[SELR_W-1:0];
    end
    assign sel_flat[r*SELR_W +: SELR_W] = sel_q[r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en <= '0;
      fall_en <= '0;
      imask   <= '0;
      emask   <= '0;
    end else if (wr_en) begin
      if (bus_addr == A_RISE) rise_en <= bus_wdata[NLINES-1:0];
      if (bus_addr == A_FALL) fall_en <= bus_wdata[NLINES-1:0];
      if (bus_addr == A_IMSK) imask   <= bus_wdata[NLINES-1:0];
      if (bus_addr == A_EMSK) emask   <= bus_wdata[NLINES-1:0];
    end
  end

  // Write-one-to-clear strobe for the pending register
  assign clr_vec = (wr_en && bus_addr == A_PEND) ? bus_wdata[NLINES-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    for (int r = 0; r < NSEL; r++)
      if (bus_addr == ADDR_W'(r)) bus_rdata = DATA_W'(sel_q[r]);
    if (bus_addr == A_RISE) bus_rdata = DATA_W'(rise_en);
    if (bus_addr == A_FALL) bus_rdata = DATA_W'(fall_en);
    if (bus_addr == A_IMSK) bus_rdata = DATA_W'(imask);
    if (bus_addr == A_EMSK) bus_rdata = DATA_W'(emask);
    if (bus_addr == A_PEND) bus_rdata = DATA_W'(pend);
  end
endmodule

// File: rtl/xl_edge.sv
module xl_edge #(
  parameter int NLINES = 16,
  parameter int NPORTS = 4,
  parameter int SEL_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*NLINES-1:0] pins,
  input  logic [NLINES*SEL_W-1:0]  sel_flat,
  output logic [NLINES-1:0]        rise_det,
  output logic [NLINES-1:0]        fall_det
);
  for (genvar n = 0; n < NLINES; n++) begin : g_line
    logic       src;
    logic [2:0] sh;  // [0] first sync stage, [1] synced, [2] previous synced

    // Port mux ahead of the synchroniser; unmatched index reads 0
    always_comb begin
      src = 1'b0;
      for (int p = 0; p < NPORTS; p++)
        if (sel_flat[n*SEL_W +: SEL_W] == SEL_W'(p))
          src = pins[p*NLINES + n];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], src};
    end

    assign rise_det[n] = sh[1] & ~sh[2];
    assign fall_det[n] = ~sh[1] & sh[2];
  end
endmodule

// File: rtl/xl_pend.sv
module xl_pend #(
  parameter int NLINES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] set_vec,
  input  logic [NLINES-1:0] clr_vec,
  output logic [NLINES-1:0] pend
);
  // A set on the same edge as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/xline_irq_ctrl.sv
module xline_irq_ctrl #(
  parameter int NLINES = 16,
  parameter int NPORTS = 4,
  parameter int SEL_W  = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*NLINES-1:0] port_pins,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic [NLINES-1:0]        irq_out,
  output logic [NLINES-1:0]        evt_out
);
  logic [NLINES*SEL_W-1:0] sel_flat;
  logic [NLINES-1:0] rise_en, fall_en, imsk_w, emsk_w, clr_w;
  logic [NLINES-1:0] rise_det, fall_det, trig_w, pend_w;

  xl_regs #(.NLINES(NLINES), .SEL_W(SEL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .pend     (pend_w),
    .bus_rdata(bus_rdata),
    .sel_flat (sel_flat),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .imask    (imsk_w),
    .emask    (emsk_w),
    .clr_vec  (clr_w)
  );

  xl_edge #(.NLINES(NLINES), .NPORTS(NPORTS), .SEL_W(SEL_W)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins    (port_pins),
    .sel_flat(sel_flat),
    .rise_det(rise_det),
    .fall_det(fall_det)
  );

  assign trig_w = (rise_det & rise_en) | (fall_det & fall_en);

  xl_pend #(.NLINES(NLINES)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(trig_w & imsk_w),
    .clr_vec(clr_w),
    .pend   (pend_w)
  );

  assign irq_out = pend_w;
  assign evt_out = trig_w & emsk_w;
endmodule

// File: rtl/xl_chk.sv
module xl_chk #(
  parameter int NLINES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] irq_out,
  input logic [NLINES-1:0] evt_out,
  input logic [NLINES-1:0] trig,
  input logic [NLINES-1:0] imask,
  input logic [NLINES-1:0] clr_vec
);
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (irq_out == '0 && evt_out == '0));

  p_pend_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_out & ~$past(irq_out) & ~($past(trig) & $past(imask))) == '0));

  p_clear_only_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq_out) & ~irq_out & ~$past(clr_vec)) == '0));

  p_clear_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_vec) & ~($past(trig) & $past(imask)) & irq_out) == '0));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(trig) & $past(imask)) & ~irq_out) == '0));
endmodule

bind xline_irq_ctrl xl_chk #(.NLINES(NLINES)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .irq_out(irq_out),
  .evt_out(evt_out),
  .trig   (trig_w),
  .imask  (imsk_w),
  .clr_vec(clr_w)
);

// File: tb/tb_xline_irq_ctrl.sv
`timescale 1ns/1ps
module tb_xline_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] port_pins = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] irq_out;
  logic [15:0] evt_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xline_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .port_pins(port_pins),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .evt_out(evt_out)
  );

  // {rise, fall, imask, emask, start, end, exp_evt, exp_irq}
  localparam logic [7:0] VEC [8] = '{
    8'b1011_0111,  // R3 rising edge, both paths
    8'b1011_1000,  // R3 falling edge ignored
    8'b0110_1001,  // R4 falling, event masked (R9)
    8'b0101_0100,  // R4 rising edge ignored
    8'b1101_0110,  // R5 rising, irq masked (R6)
    8'b1110_1001,  // R5 falling
    8'b0011_0100,  // R10 rising, no enable
    8'b0011_1000   // R10 falling, no enable
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 irq", irq_out, 16'h0);
    chk("R1 evt", evt_out, 16'h0);
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), rv);
      chk($sformatf("R1 reg%0d", a), rv, 16'h0);
    end

    // Vector table walk
    for (int k = 0; k < 8; k++) begin
      int ln;
      int pt;
      logic [7:0] v;
      ln = k + 3;
      pt = k % 4;
      v  = VEC[k];
      port_pins[pt*16 + ln] = v[3];
      wr(4'(ln / 4), 16'(pt) << (4 * (ln % 4)));
      idle(4);
      wr(4'd4, v[7] ? 16'(1) << ln : 16'h0);
      wr(4'd5, v[6] ? 16'(1) << ln : 16'h0);
      wr(4'd6, v[5] ? 16'(1) << ln : 16'h0);
      wr(4'd7, v[4] ? 16'(1) << ln : 16'h0);
      wr(4'd8, 16'hFFFF);
      port_pins[pt*16 + ln] = v[2];
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("vec%0d evt pulse (R3 R4 R5 R9 R10)", k), evt_out, v[1] ? 16'(1) << ln : 16'h0);
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("vec%0d evt one cycle R9", k), evt_out, 16'h0);
      chk($sformatf("vec%0d irq (R6 R10)", k), irq_out, v[0] ? 16'(1) << ln : 16'h0);
    end
    wr(4'd4, 16'h0); wr(4'd5, 16'h0); wr(4'd6, 16'h0); wr(4'd7, 16'h0);
    wr(4'd8, 16'hFFFF);

    // R2: select field layout and source mapping
    wr(4'd1, 16'h3210);
    rd(4'd1, rv);
    chk("R2 readback", rv, 16'h3210);
    wr(4'd1, 16'h0020);       // line 5 <- port 2
    idle(4);
    wr(4'd4, 16'h0020);
    wr(4'd6, 16'h0020);
    wr(4'd8, 16'hFFFF);
    port_pins[0*16 + 5] = 1'b1;
    idle(5);
    chk("R2 unselected port", irq_out, 16'h0);
    port_pins[2*16 + 5] = 1'b1;
    idle(5);
    chk("R2 selected port", irq_out, 16'h0020);
    wr(4'd1, 16'h0090);       // index 9: no such port
    idle(4);
    wr(4'd8, 16'hFFFF);
    port_pins[2*16 + 5] = 1'b0;
    idle(4);
    port_pins[2*16 + 5] = 1'b1;
    idle(5);
    chk("R2 out-of-range index", irq_out, 16'h0);

    // R7: write-one-to-clear
    wr(4'd1, 16'h0020);
    idle(4);
    wr(4'd8, 16'hFFFF);
    port_pins[2*16 + 5] = 1'b0;
    idle(4);
    port_pins[2*16 + 5] = 1'b1;
    idle(5);
    chk("R7 set before clear", irq_out, 16'h0020);
    wr(4'd8, 16'hFFDF);
    chk("R7 zero bit keeps", irq_out, 16'h0020);
    rd(4'd8, rv);
    chk("R7 readback", rv, 16'h0020);
    wr(4'd8, 16'h0020);
    chk("R7 one bit clears", irq_out, 16'h0);

    // R8: set and clear on the same edge
    wr(4'd5, 16'h0020);
    port_pins[2*16 + 5] = 1'b0;
    idle(5);
    chk("R8 pending before", irq_out, 16'h0020);
    port_pins[2*16 + 5] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd8; bus_wdata = 16'h0020;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    chk("R8 set wins", irq_out, 16'h0020);
    wr(4'd8, 16'h0020);
    chk("R8 later clear", irq_out, 16'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule